// File: doc/BRIEF.md
# Host Bus Type Auto-Detector

This block sits behind the pins of an 8-bit host port. From the traffic the host drives after a hardware reset, it works out two properties of the port. The first is the strobe style: either two separate active-low read and write strobes, or a direction line paired with a single active-low data strobe. The second is whether the address and data share pins (multiplexed) or not. Both properties are presented as mode flags. The block also gives downstream register logic a pair of normalised internal strobes, read and write, each qualified by chip select.

The pins are resynchronised through a parameterised number of flops. The strobe style is judged on the falling edge of the write-side pin. A read-side pin that is still high at that edge means separate strobes. A read-side pin that is already low means that pin is a direction line. The bus type starts as multiplexed. It switches to non-multiplexed the first time address bit 0 is seen high while any strobe is active. Each decision has its own lock. The lock is set by that decision's first qualifying event. Both locks are forced on by the first chip-selected read. After that the flags hold until the next hardware reset. No configuration pins are needed.

Top module: `host_bus_detect`

## Requirements
- R1: While and after reset, before any host activity, style_ds_o is 0 (separate strobes), bus_demux_o is 0 (multiplexed), and rd_o and wr_o are 0.
- R2: On a high-to-low transition of the synchronised wr_ni pin, with the style not yet locked, style_ds_o takes the inverse of the synchronised rd_ni level and the style locks; cs_ni plays no part in this.
- R3: While the bus type is unlocked, any cycle with a strobe active and a0_i high sets bus_demux_o to 1 and locks it; chip select is not required. A strobe is active when wr_ni is low, or when rd_ni is low in separate-strobe style.
- R4: Accesses with a0_i low leave bus_demux_o at 0 and do not lock the bus type.
- R5: Once a decision is locked, later events of its kind do not change its flag until reset. The two locks are independent of each other.
- R6: A cycle with cs_ni low and the internal read active locks both decisions. An a0_i-high observation in that same cycle is still applied. This holds even when no write came first.
- R7: In separate-strobe style, rd_o = !cs_ni & !rd_ni and wr_o = !cs_ni & !wr_ni.
- R8: In direction-plus-strobe style, rd_ni is the direction line (1 = read) and wr_ni is the data strobe: rd_o = !cs_ni & rd_ni & !wr_ni, and wr_o = !cs_ni & !rd_ni & !wr_ni. The style decided in a cycle already applies to that cycle's strobes.
- R9: rd_o and wr_o follow the pins after SYNC_STAGES clock edges. The mode flags update one edge after the sampled event.
- R10: A write with a0_i high, followed by a chip-selected read with a0_i high, leaves both decisions settled and locked in either strobe style.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous hardware reset |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, or direction line (1 = read) |
| wr_ni | input | 1 | Write strobe, or data strobe |
| a0_i | input | 1 | Address bit 0 |
| style_ds_o | output | 1 | 1 = direction plus data strobe style |
| bus_demux_o | output | 1 | 1 = non-multiplexed bus |
| rd_o | output | 1 | Normalised internal read, chip-select qualified |
| wr_o | output | 1 | Normalised internal write, chip-select qualified |

## Verification
Two pairs of functions can land in the same sampled cycle. A write edge with a0_i high decides the strobe style and the bus type together. A first chip-selected read with a0_i high both freezes the decisions and supplies the bus observation. Both cases are provoked directly: by an odd-address write at the start of a session, and by an odd-address read with no earlier write. They are judged two ways. A behavioural reference model is compared with the outputs on every clock. Fixed expected flag values are also checked once the pipeline has drained.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
  typedef struct packed {
    logic cs_n;
    logic rd_n;
    logic wr_n;
    logic a0;
  } host_pins_t;

  localparam host_pins_t PINS_IDLE = '{cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1, a0: 1'b0};

  typedef enum logic {STYLE_SPLIT = 1'b0, STYLE_DIR_DS = 1'b1} strobe_style_e;
  typedef enum logic {BUS_MUX = 1'b0, BUS_DEMUX = 1'b1} bus_kind_e;
endpackage

// File: rtl/hbd_pin_sync.sv
module hbd_pin_sync
  import hbd_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  host_pins_t pins_i,
  output host_pins_t pins_o,
  output logic       prev_wr_no
);
  localparam int LAST = STAGES - 1;

  host_pins_t [LAST:0] stg_q;
  logic                prev_wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= PINS_IDLE;
      prev_wr_q <= 1'b1;
    end else begin
      stg_q[0]  <= pins_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      prev_wr_q <= stg_q[LAST].wr_n;
    end
  end

  assign pins_o     = stg_q[LAST];
  assign prev_wr_no = prev_wr_q;

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (pins_o == PINS_IDLE)) else $error("sync not idle"); // R1
endmodule

// File: rtl/hbd_style_detect.sv
module hbd_style_detect
  import hbd_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  host_pins_t    pins_i,
  input  logic          prev_wr_ni,
  input  logic          freeze_i,
  output strobe_style_e style_o,
  output strobe_style_e style_nx_o,
  output logic          lock_o
);
  strobe_style_e style_q;
  logic          lock_q;
  logic          wr_edge;

  assign wr_edge = prev_wr_ni && !pins_i.wr_n;

  // read-side pin still high at write edge: separate strobes
  always_comb begin
    style_nx_o = style_q;
    if (!lock_q && wr_edge) style_nx_o = pins_i.rd_n ? STYLE_SPLIT : STYLE_DIR_DS;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      style_q <= STYLE_SPLIT;
      lock_q  <= 1'b0;
    end else if (!lock_q) begin
      style_q <= style_nx_o;
      if (wr_edge || freeze_i) lock_q <= 1'b1;
    end
  end

  assign style_o = style_q;
  assign lock_o  = lock_q;

  AST_STYLE_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_q |-> (style_q == STYLE_SPLIT)) else $error("style moved while unlocked"); // R1
  AST_STYLE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> ($stable(style_q) && lock_q)) else $error("style changed after lock"); // R5
  AST_STYLE_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) && !$past(freeze_i) |-> $past(prev_wr_ni && !pins_i.wr_n)) else $error("style lock without write edge"); // R2
endmodule

// File: rtl/hbd_strobe_norm.sv
module hbd_strobe_norm
  import hbd_pkg::*;
(
  input  host_pins_t    pins_i,
  input  strobe_style_e style_i,
  output logic          rd_int_o,
  output logic          wr_int_o,
  output logic          any_strobe_o
);
  always_comb begin
    if (style_i == STYLE_DIR_DS) begin
      rd_int_o     = pins_i.rd_n && !pins_i.wr_n;
      wr_int_o     = !pins_i.rd_n && !pins_i.wr_n;
      any_strobe_o = !pins_i.wr_n;
    end else begin
      rd_int_o     = !pins_i.rd_n;
      wr_int_o     = !pins_i.wr_n;
      any_strobe_o = !pins_i.wr_n || !pins_i.rd_n;
    end
  end

  always_comb begin
    if (style_i == STYLE_DIR_DS)
      AST_DS_EXCLUSIVE: assert (!(rd_int_o && wr_int_o)) else $error("read and write together"); // R8
  end
endmodule

// File: rtl/hbd_bus_detect.sv
module hbd_bus_detect
  import hbd_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      a0_i,
  input  logic      strobe_i,
  input  logic      freeze_i,
  output bus_kind_e bus_o,
  output logic      lock_o
);
  bus_kind_e bus_q;
  logic      lock_q;
  logic      odd_seen;

  assign odd_seen = strobe_i && a0_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_q  <= BUS_MUX;
      lock_q <= 1'b0;
    end else if (!lock_q) begin
      if (odd_seen) bus_q <= BUS_DEMUX;
      if (odd_seen || freeze_i) lock_q <= 1'b1;
    end
  end

  assign bus_o  = bus_q;
  assign lock_o = lock_q;

  AST_BUS_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_q |-> (bus_q == BUS_MUX)) else $error("bus moved while unlocked"); // R1
  AST_BUS_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> ($stable(bus_q) && lock_q)) else $error("bus changed after lock"); // R5
  AST_DEMUX_NEEDS_A0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_q == BUS_MUX) ##1 (bus_q == BUS_DEMUX) |-> $past(a0_i && strobe_i)) else $error("demux without odd access"); // R3
endmodule

// File: rtl/host_bus_detect.sv
module host_bus_detect
  import hbd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic rd_ni,
  input  logic wr_ni,
  input  logic a0_i,
  output logic style_ds_o,
  output logic bus_demux_o,
  output logic rd_o,
  output logic wr_o
);
  host_pins_t    pins_raw, pins_s;
  logic          prev_wr_n;
  strobe_style_e style, style_nx;
  bus_kind_e     bus;
  logic          style_lock, bus_lock;
  logic          rd_int, wr_int, any_strobe, freeze;

  assign pins_raw = '{cs_n: cs_ni, rd_n: rd_ni, wr_n: wr_ni, a0: a0_i};

  hbd_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .pins_i(pins_raw),
    .pins_o(pins_s), .prev_wr_no(prev_wr_n)
  );

  hbd_style_detect u_style (
    .clk_i(clk_i), .rst_ni(rst_ni), .pins_i(pins_s), .prev_wr_ni(prev_wr_n),
    .freeze_i(freeze), .style_o(style), .style_nx_o(style_nx), .lock_o(style_lock)
  );

  hbd_strobe_norm u_norm (
    .pins_i(pins_s), .style_i(style_nx),
    .rd_int_o(rd_int), .wr_int_o(wr_int), .any_strobe_o(any_strobe)
  );

  assign freeze = !pins_s.cs_n && rd_int;

  hbd_bus_detect u_bus (
    .clk_i(clk_i), .rst_ni(rst_ni), .a0_i(pins_s.a0), .strobe_i(any_strobe),
    .freeze_i(freeze), .bus_o(bus), .lock_o(bus_lock)
  );

  assign style_ds_o  = (style == STYLE_DIR_DS);
  assign bus_demux_o = (bus == BUS_DEMUX);
  assign rd_o        = !pins_s.cs_n && rd_int;
  assign wr_o        = !pins_s.cs_n && wr_int;

  AST_FREEZE_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |=> (style_lock && bus_lock)) else $error("read did not freeze"); // R6
  AST_NO_STROBE_UNSELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pins_s.cs_n |-> (!rd_o && !wr_o)) else $error("strobe without select"); // R7
endmodule

// File: tb/sim_host_bus_detect.sv
module sim_host_bus_detect;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic b_cs = 1'b1, b_rd = 1'b1, b_wr = 1'b1, b_a0 = 1'b0;
  logic style_ds, bus_demux, rd_o, wr_o;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;
  string phase = "R1";

  always #4 clk = ~clk;

  host_bus_detect #(.SYNC_STAGES(SYNC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(b_cs), .rd_ni(b_rd), .wr_ni(b_wr), .a0_i(b_a0),
    .style_ds_o(style_ds), .bus_demux_o(bus_demux), .rd_o(rd_o), .wr_o(wr_o)
  );

  // behavioural reference: pin queue plus decision state
  logic [3:0] pq[$];
  logic [3:0] cur;
  bit m_style, m_bus, m_sl, m_bl, m_pwr;

  function automatic bit nx_style();
    if (!m_sl && m_pwr && !cur[1]) return !cur[2];
    return m_style;
  endfunction

  function automatic bit exp_rd();
    bit s = nx_style();
    return !cur[3] && (s ? (cur[2] && !cur[1]) : !cur[2]);
  endfunction

  function automatic bit exp_wr();
    bit s = nx_style();
    return !cur[3] && (s ? (!cur[2] && !cur[1]) : !cur[1]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pq.delete();
      for (int i = 0; i < SYNC - 1; i++) pq.push_back(4'b1110);
      cur = 4'b1110;
      m_style = 0; m_bus = 0; m_sl = 0; m_bl = 0; m_pwr = 1;
    end else begin
      bit s, strobe, frz, rdi;
      s = nx_style();
      rdi = s ? (cur[2] && !cur[1]) : !cur[2];
      strobe = !cur[1] || (!s && !cur[2]);
      frz = !cur[3] && rdi;
      if (!m_bl) begin
        if (strobe && cur[0]) m_bus = 1;
        if ((strobe && cur[0]) || frz) m_bl = 1;
      end
      if (!m_sl) begin
        m_style = s;
        if ((m_pwr && !cur[1]) || frz) m_sl = 1;
      end
      m_pwr = cur[1];
      pq.push_back({b_cs, b_rd, b_wr, b_a0});
      cur = pq.pop_front();
    end
  end

  task automatic chk(string req, string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(phase, "model style", style_ds, m_style);
      chk(phase, "model bus", bus_demux, m_bus);
      chk(phase, "model rd", rd_o, exp_rd());
      chk(phase, "model wr", wr_o, exp_wr());
    end
  end

  task automatic drive(bit cs, bit rd, bit wr, bit a0, int n);
    b_cs = cs; b_rd = rd; b_wr = wr; b_a0 = a0;
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic idle(int n);
    drive(1, 1, 1, 0, n);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(3);
    chk("R1", "reset style", style_ds, 0);
    chk("R1", "reset bus", bus_demux, 0);
    chk("R1", "reset rd", rd_o, 0);
    chk("R1", "reset wr", wr_o, 0);
    rst_n = 1'b1;
    idle(4);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // separate strobes, odd write to foreign memory decides both at once (R2, R3)
    phase = "R1"; do_reset();
    chk("R1", "idle style", style_ds, 0);
    chk("R1", "idle bus", bus_demux, 0);
    phase = "R2"; drive(1, 1, 0, 1, 4);
    chk("R2", "no select wr", wr_o, 0);
    idle(4);
    chk("R2", "split style", style_ds, 0);
    chk("R3", "demux", bus_demux, 1);
    phase = "R7"; drive(0, 0, 1, 1, 4);
    chk("R7", "split rd", rd_o, 1);
    chk("R7", "split wr", wr_o, 0);
    idle(2);
    drive(0, 1, 0, 0, 4);
    chk("R7", "split wr2", wr_o, 1);
    idle(2);
    phase = "R5"; drive(1, 0, 1, 0, 2); drive(1, 0, 0, 0, 4);
    idle(4);
    chk("R5", "style kept", style_ds, 0);

    // direction plus data strobe, odd write then odd read (R8, R10)
    phase = "R8"; do_reset();
    drive(1, 0, 1, 1, 2);
    drive(0, 0, 0, 1, 4);
    chk("R8", "ds wr", wr_o, 1);
    chk("R8", "ds no rd", rd_o, 0);
    drive(0, 0, 1, 1, 2);
    idle(3);
    chk("R8", "ds style", style_ds, 1);
    chk("R10", "ds demux", bus_demux, 1);
    drive(0, 1, 0, 1, 4);
    chk("R8", "ds rd", rd_o, 1);
    chk("R8", "ds rd no wr", wr_o, 0);
    idle(4);
    chk("R10", "ds style held", style_ds, 1);
    chk("R10", "ds bus held", bus_demux, 1);

    // multiplexed host: even accesses only, then freeze (R4, R6)
    phase = "R4"; do_reset();
    drive(1, 1, 0, 0, 4); idle(3);
    chk("R4", "mux after write", bus_demux, 0);
    drive(0, 0, 1, 0, 4); idle(3);
    chk("R4", "mux after read", bus_demux, 0);
    phase = "R6"; drive(1, 0, 1, 1, 4); idle(3);
    chk("R6", "frozen mux", bus_demux, 0);

    // freeze without prior write, odd read in the same cycle (R6)
    phase = "R6"; do_reset();
    drive(0, 0, 1, 1, 4); idle(3);
    chk("R6", "freeze bus odd", bus_demux, 1);
    chk("R6", "freeze style", style_ds, 0);
    drive(1, 0, 1, 0, 2); drive(1, 0, 0, 0, 4); idle(4);
    chk("R6", "style frozen", style_ds, 0);

    // style locks alone, bus decided later (R3, R5)
    phase = "R3"; do_reset();
    drive(1, 1, 0, 0, 4); idle(3);
    chk("R5", "bus still open", bus_demux, 0);
    drive(1, 0, 1, 1, 4); idle(3);
    chk("R3", "later odd read", bus_demux, 1);
    chk("R5", "style independent", style_ds, 0);

    // latency: strobe visible after SYNC edges (R9)
    phase = "R9"; do_reset();
    b_cs = 0; b_rd = 0;
    repeat (SYNC - 1) @(posedge clk);
    #2 chk("R9", "rd early", rd_o, 0);
    @(posedge clk);
    #2 chk("R9", "rd on time", rd_o, 1);
    idle(4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule